// File: doc/BRIEF.md
# Debug Hart-Interface Window

This block is the memory-mapped slave that harts running a debug park loop use to talk to the debug-module controller. It decodes a 4 KiB window into five parts:

- a one-word alert-test register;
- four write-only event registers, through which a hart reports that it halted, that it is leaving for the command slot, that it is resuming, or that it took an exception;
- a 256-byte shared RAM, holding the jump slot followed by command and program words;
- a flag array with one byte per hart, carrying go and resume requests;
- a read-only window onto an external debug ROM.

Every event write that matters becomes a one-cycle acknowledge strobe toward the controller. Halt and resume strobes come with the hart id. The block keeps one idle bit per hart. A hart that spins in the park loop and reports its halt over and over produces only one halt acknowledge until it leaves the loop again.

Only the debug-module requester may write the flag bytes. The same writes from a hart complete normally but change nothing. Every access gets a response exactly one cycle after it is presented. The response is a 2-bit code: OK, error or decode error.

Top module: `dm_hart_window`

## Requirements
- R1: Reset clears the shared RAM, all flag bytes, the idle bitmap and the alert output. It also drives every acknowledge strobe and the response-valid output low.
- R2: A write of hart id h to offset 0x100, with h below the hart count and h's idle bit clear, gives one ackHalted strobe with ackHartId = h and sets idle bit h. Further such writes while the bit is set produce no strobe.
- R3: A write to offset 0x100 with a value not below the hart count produces no strobe and leaves the idle bitmap unchanged.
- R4: A write of value v to offset 0x104 always gives one ackGoing strobe. It clears idle bit v when v is below the hart count and changes no idle bit otherwise.
- R5: A write of hart id h to offset 0x108, with h below the hart count, clears idle bit h and gives one ackResuming strobe with ackHartId = h. A value not below the hart count does neither.
- R6: A write to offset 0x10C gives one ackException strobe.
- R7: The event registers (0x100 to 0x10F) behave as follows:
  - a word-aligned read returns zero with OK;
  - any access with address bit 0 set returns error (code 1) and has no effect.
- R8: The flag array starts at 0x400, holding one byte per hart. Hart h's byte sits at byte lane h mod 4 of word h div 4; bit 0 is go and bit 1 is resume. A write with busDbgReq high stores the word. A write with busDbgReq low returns OK and leaves the stored flags unchanged.
- R9: The shared RAM covers 0x300 to 0x3FF. Any master may read and write it, and word 0 is the jump slot.
- R10: Reads from 0x800 to 0xFFF return OK with romData, taken in the request cycle while romIdx = address bits 10:2. Writes there return error and change nothing.
- R11: Writing offset 0x000 sets alertFatal to bit 0 of the written value, and alertFatal holds until the next such write. A read of 0x000 returns zero.
- R12: Any other offset returns decode error (code 2). This includes 0x200 and flag words at or beyond the hart count.
- R13: busRspVld is high exactly in the cycle after a request, carrying the code and read data, and low otherwise. The hart count is the CPU-count parameter capped at 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Access request, one cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset inside the window |
| busWdata | input | 32 | Write data |
| busDbgReq | input | 1 | Access comes from the debug-module requester |
| busRspVld | output | 1 | Response valid, one cycle after busReq |
| busRsp | output | 2 | 0 OK, 1 error, 2 decode error |
| busRdata | output | 32 | Read data, valid with busRspVld |
| romIdx | output | 9 | Word index into the external debug ROM |
| romData | input | 32 | ROM word for romIdx, same cycle |
| ackHalted | output | 1 | Halt acknowledge strobe |
| ackGoing | output | 1 | Going acknowledge strobe |
| ackResuming | output | 1 | Resume acknowledge strobe |
| ackException | output | 1 | Exception acknowledge strobe |
| ackHartId | output | 6 | Hart id written with the strobed event |
| idleMap | output | HARTS | Per-hart idle bitmap |
| alertFatal | output | 1 | Fatal alert line |

## Verification
The bench covers a hart that reports its halt repeatedly. A design without the idle-bit filter would emit a halt strobe on every report, and one that never cleared the bit on resume would go silent on the next halt.

Hart ids at and above the hart count go to the halt, going and resume registers. A bad range check would set or clear a wrong idle bit or strobe for a hart that does not exist.

A flag write from a hart must complete OK while leaving the stored bytes untouched. A design that trusted every master would change them.

Odd event addresses, ROM writes and the gap at 0x200 each need their own response code. A decoder that merged these cases would report the wrong one.

// File: rtl/dm_hart_window_pkg.sv
package dm_hart_window_pkg;

  typedef enum logic [1:0] {
    RSP_OK     = 2'd0,
    RSP_ERR    = 2'd1,
    RSP_DECERR = 2'd2
  } rspCode_e;

  // Strobes from the decoder to the storage/ack datapath, valid in the request cycle
  typedef struct packed {
    logic       ramWr;
    logic       ramRd;
    logic       flagWr;
    logic       flagRd;
    logic       romRd;
    logic       haltWr;
    logic       goWr;
    logic       resumeWr;
    logic       excWr;
    logic       alertWr;
    logic [5:0] ramIdx;
    logic [3:0] flagIdx;
  } ctlStrobe_t;

  localparam int unsigned RAM_WORDS  = 64;
  localparam int unsigned MAX_HARTS  = 64;
  localparam int unsigned HART_ID_W  = 6;

endpackage

// File: rtl/dm_hart_window_ctl.sv
module dm_hart_window_ctl
  import dm_hart_window_pkg::*;
#(
  parameter int unsigned HARTS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busReq,
  input  logic        busWe,
  input  logic [11:0] busAddr,
  input  logic        busDbgReq,
  output ctlStrobe_t  ctl,
  output logic        busRspVld,
  output logic [1:0]  busRsp,
  output logic [8:0]  romIdx
);

  localparam int unsigned FLAG_WORDS = (HARTS + 3) / 4;

  logic isRom, isAlert, isAct, isRam, isFlag, okAcc;
  rspCode_e code, rspQ;
  logic unusedAddrBit;

  assign unusedAddrBit = busAddr[1];
  assign romIdx        = busAddr[10:2];

  always_comb begin
    isRom   = busAddr[11];
    isAlert = (busAddr[11:2] == 10'd0);
    isAct   = (busAddr[11:4] == 8'h10);
    isRam   = (busAddr[11:8] == 4'h3);
    isFlag  = (busAddr[11:8] == 4'h4) && (32'(busAddr[7:2]) < FLAG_WORDS);

    if (isAct && busAddr[0])             code = RSP_ERR;
    else if (isRom && busWe)             code = RSP_ERR;
    else if (isRom || isAlert || isAct || isRam || isFlag) code = RSP_OK;
    else                                 code = RSP_DECERR;

    okAcc = busReq && (code == RSP_OK);

    ctl          = '0;
    ctl.ramIdx   = busAddr[7:2];
    ctl.flagIdx  = busAddr[5:2];
    ctl.ramWr    = okAcc && isRam && busWe;
    ctl.ramRd    = okAcc && isRam && !busWe;
    ctl.flagWr   = okAcc && isFlag && busWe && busDbgReq;
    ctl.flagRd   = okAcc && isFlag && !busWe;
    ctl.romRd    = okAcc && isRom;
    ctl.alertWr  = okAcc && isAlert && busWe;
    ctl.haltWr   = okAcc && isAct && busWe && (busAddr[3:2] == 2'd0);
    ctl.goWr     = okAcc && isAct && busWe && (busAddr[3:2] == 2'd1);
    ctl.resumeWr = okAcc && isAct && busWe && (busAddr[3:2] == 2'd2);
    ctl.excWr    = okAcc && isAct && busWe && (busAddr[3:2] == 2'd3);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRspVld <= 1'b0;
      rspQ      <= RSP_OK;
    end else begin
      busRspVld <= busReq;
      rspQ      <= code;
    end
  end

  assign busRsp = rspQ;

  // R13
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq |=> busRspVld);

  // R13
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |=> !busRspVld);

  // R10
  rom_write_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWe && busAddr[11]) |=> (busRsp == RSP_ERR));

  // R7
  odd_act_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAddr[11:4] == 8'h10 && busAddr[0]) |=> (busRsp == RSP_ERR));

endmodule

// File: rtl/dm_hart_window_dp.sv
module dm_hart_window_dp
  import dm_hart_window_pkg::*;
#(
  parameter int unsigned HARTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           ctl,
  input  logic [31:0]          busWdata,
  input  logic [31:0]          romData,
  output logic [31:0]          busRdata,
  output logic                 ackHalted,
  output logic                 ackGoing,
  output logic                 ackResuming,
  output logic                 ackException,
  output logic [HART_ID_W-1:0] ackHartId,
  output logic [HARTS-1:0]     idleMap,
  output logic                 alertFatal
);

  localparam int unsigned FLAG_WORDS = (HARTS + 3) / 4;

  logic [31:0]              ramMem [RAM_WORDS];
  logic [FLAG_WORDS*32-1:0] flagVec;
  logic [HARTS-1:0]         selMask;
  logic                     inRange, selIdle;
  logic [31:0]              flagWord, rdNext;

  always_comb begin
    for (int h = 0; h < HARTS; h++) selMask[h] = (busWdata == 32'(h));
    inRange = |selMask;
    selIdle = |(idleMap & selMask);
  end

  always_comb begin
    flagWord = '0;
    for (int w = 0; w < FLAG_WORDS; w++)
      if (ctl.flagIdx == 4'(w)) flagWord = flagVec[w*32 +: 32];
  end

  always_comb begin
    rdNext = '0;
    if (ctl.ramRd)       rdNext = ramMem[ctl.ramIdx];
    else if (ctl.flagRd) rdNext = flagWord;
    else if (ctl.romRd)  rdNext = romData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_WORDS; i++) ramMem[i] <= '0;
    end else if (ctl.ramWr) begin
      ramMem[ctl.ramIdx] <= busWdata;
    end
  end

  for (genvar w = 0; w < FLAG_WORDS; w++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                                      flagVec[w*32 +: 32] <= '0;
      else if (ctl.flagWr && ctl.flagIdx == 4'(w))    flagVec[w*32 +: 32] <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleMap      <= '0;
      ackHalted    <= 1'b0;
      ackGoing     <= 1'b0;
      ackResuming  <= 1'b0;
      ackException <= 1'b0;
      ackHartId    <= '0;
      alertFatal   <= 1'b0;
      busRdata     <= '0;
    end else begin
      busRdata     <= rdNext;
      ackHalted    <= 1'b0;
      ackGoing     <= 1'b0;
      ackResuming  <= 1'b0;
      ackException <= 1'b0;
      if (ctl.alertWr) alertFatal <= busWdata[0];
      if (ctl.haltWr || ctl.goWr || ctl.resumeWr || ctl.excWr)
        ackHartId <= busWdata[HART_ID_W-1:0];
      if (ctl.haltWr && inRange && !selIdle) begin
        ackHalted <= 1'b1;
        idleMap   <= idleMap | selMask;
      end
      if (ctl.goWr) begin
        ackGoing <= 1'b1;
        idleMap  <= idleMap & ~selMask;
      end
      if (ctl.resumeWr && inRange) begin
        ackResuming <= 1'b1;
        idleMap     <= idleMap & ~selMask;
      end
      if (ctl.excWr) ackException <= 1'b1;
    end
  end

  logic [HARTS-1:0] ackSel;
  assign ackSel = HARTS'(1) << ackHartId;

  // R2
  halt_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackHalted |-> ((idleMap & ackSel) != '0) && (($past(idleMap) & ackSel) == '0));

  // R5
  resume_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackResuming |-> ((idleMap & ackSel) == '0));

  // R8
  flag_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.flagWr |=> $stable(flagVec));

  // R11
  alert_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.alertWr |=> $stable(alertFatal));

  // R6
  ack_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ackHalted, ackGoing, ackResuming, ackException}));

endmodule

// File: rtl/dm_hart_window.sv
module dm_hart_window
  import dm_hart_window_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 4,
  localparam int unsigned HARTS = (NUM_CPUS > MAX_HARTS) ? MAX_HARTS : NUM_CPUS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busReq,
  input  logic                 busWe,
  input  logic [11:0]          busAddr,
  input  logic [31:0]          busWdata,
  input  logic                 busDbgReq,
  output logic                 busRspVld,
  output logic [1:0]           busRsp,
  output logic [31:0]          busRdata,
  output logic [8:0]           romIdx,
  input  logic [31:0]          romData,
  output logic                 ackHalted,
  output logic                 ackGoing,
  output logic                 ackResuming,
  output logic                 ackException,
  output logic [HART_ID_W-1:0] ackHartId,
  output logic [HARTS-1:0]     idleMap,
  output logic                 alertFatal
);

  ctlStrobe_t ctl;

  dm_hart_window_ctl #(.HARTS(HARTS)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .busReq    (busReq),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .busDbgReq (busDbgReq),
    .ctl       (ctl),
    .busRspVld (busRspVld),
    .busRsp    (busRsp),
    .romIdx    (romIdx)
  );

  dm_hart_window_dp #(.HARTS(HARTS)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .busWdata     (busWdata),
    .romData      (romData),
    .busRdata     (busRdata),
    .ackHalted    (ackHalted),
    .ackGoing     (ackGoing),
    .ackResuming  (ackResuming),
    .ackException (ackException),
    .ackHartId    (ackHartId),
    .idleMap      (idleMap),
    .alertFatal   (alertFatal)
  );

endmodule

// File: tb/dm_hart_window_tb.sv
module dm_hart_window_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWe = 1'b0, busDbgReq = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busRspVld;
  logic [1:0]  busRsp;
  logic [31:0] busRdata, romData;
  logic [8:0]  romIdx;
  logic        ackHalted, ackGoing, ackResuming, ackException, alertFatal;
  logic [5:0]  ackHartId;
  logic [3:0]  idleMap;

  int checks = 0;
  int failures = 0;

  // captured per access
  logic [1:0]  cRsp;
  logic [31:0] cData;
  logic        cVld, cHalt, cGo, cRes, cExc;
  logic [5:0]  cId;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign romData = {16'hC0DE, 7'd0, romIdx};

  dm_hart_window #(.NUM_CPUS(4)) u_dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busDbgReq(busDbgReq), .busRspVld(busRspVld),
    .busRsp(busRsp), .busRdata(busRdata), .romIdx(romIdx), .romData(romData),
    .ackHalted(ackHalted), .ackGoing(ackGoing), .ackResuming(ackResuming),
    .ackException(ackException), .ackHartId(ackHartId), .idleMap(idleMap),
    .alertFatal(alertFatal)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [11:0] addr, input logic [31:0] data, input bit dbg);
    @(negedge clk);
    busReq = 1'b1; busWe = we; busAddr = addr; busWdata = data; busDbgReq = dbg;
    @(negedge clk);
    cVld = busRspVld; cRsp = busRsp; cData = busRdata;
    cHalt = ackHalted; cGo = ackGoing; cRes = ackResuming; cExc = ackException; cId = ackHartId;
    busReq = 1'b0; busWe = 1'b0; busDbgReq = 1'b0;
    chk(cVld == 1'b1, "R13 response valid after request", 32'(cVld), 32'd1);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    chk(idleMap == 4'd0, "R1 idle map after reset", 32'(idleMap), 0);
    chk(alertFatal == 1'b0, "R1 alert after reset", 32'(alertFatal), 0);
    chk({ackHalted, ackGoing, ackResuming, ackException, busRspVld} == 5'd0,
        "R1 strobes after reset", 32'({ackHalted, ackGoing, ackResuming, ackException, busRspVld}), 0);
    access(1'b0, 12'h300, 0, 1'b0);
    chk(cData == 0 && cRsp == 2'd0, "R1 shared RAM cleared", cData, 0);
    access(1'b0, 12'h400, 0, 1'b0);
    chk(cData == 0 && cRsp == 2'd0, "R1 flags cleared", cData, 0);
  endtask

  task automatic testHalt();
    access(1'b1, 12'h100, 32'd2, 1'b0);
    chk(cHalt == 1'b1 && cId == 6'd2, "R2 first halt ack with id", {26'd0, cId}, 2);
    chk(idleMap == 4'b0100, "R2 idle bit set", 32'(idleMap), 32'h4);
    access(1'b1, 12'h100, 32'd2, 1'b0);
    chk(cHalt == 1'b0, "R2 repeated halt suppressed", 32'(cHalt), 0);
    access(1'b1, 12'h100, 32'd4, 1'b0);
    chk(cHalt == 1'b0 && idleMap == 4'b0100, "R3 halt id equal to count ignored", 32'(idleMap), 32'h4);
    access(1'b1, 12'h100, 32'h0001_0001, 1'b0);
    chk(cHalt == 1'b0 && idleMap == 4'b0100, "R3 large halt value ignored", 32'(idleMap), 32'h4);
  endtask

  task automatic testGoing();
    access(1'b1, 12'h104, 32'd9, 1'b0);
    chk(cGo == 1'b1 && idleMap == 4'b0100, "R4 going out of range keeps map", 32'(idleMap), 32'h4);
    access(1'b1, 12'h104, 32'd2, 1'b0);
    chk(cGo == 1'b1 && cHalt == 1'b0, "R4 going strobe", 32'(cGo), 1);
    chk(idleMap == 4'b0000, "R4 going clears idle bit", 32'(idleMap), 0);
  endtask

  task automatic testResume();
    access(1'b1, 12'h100, 32'd1, 1'b0);
    chk(cHalt == 1'b1 && idleMap == 4'b0010, "R2 halt hart 1", 32'(idleMap), 32'h2);
    access(1'b1, 12'h108, 32'd5, 1'b0);
    chk(cRes == 1'b0 && idleMap == 4'b0010, "R5 resume out of range ignored", 32'(idleMap), 32'h2);
    access(1'b1, 12'h108, 32'd1, 1'b0);
    chk(cRes == 1'b1 && cId == 6'd1, "R5 resume ack with id", {26'd0, cId}, 1);
    chk(idleMap == 4'b0000, "R5 resume clears idle bit", 32'(idleMap), 0);
    access(1'b1, 12'h100, 32'd1, 1'b0);
    chk(cHalt == 1'b1, "R2 halt acked again after resume", 32'(cHalt), 1);
  endtask

  task automatic testException();
    access(1'b1, 12'h10C, 32'd0, 1'b0);
    chk(cExc == 1'b1 && cHalt == 1'b0, "R6 exception strobe", 32'(cExc), 1);
  endtask

  task automatic testActRead();
    access(1'b0, 12'h104, 0, 1'b0);
    chk(cRsp == 2'd0 && cData == 0 && cGo == 1'b0, "R7 event read zero ok", cData, 0);
    access(1'b1, 12'h105, 32'd3, 1'b0);
    chk(cRsp == 2'd1 && cGo == 1'b0, "R7 odd event address error", 32'(cRsp), 1);
  endtask

  task automatic testFlags();
    access(1'b1, 12'h400, 32'h0201_0102, 1'b1);
    chk(cRsp == 2'd0, "R8 debugger flag write ok", 32'(cRsp), 0);
    access(1'b0, 12'h400, 0, 1'b0);
    chk(cData == 32'h0201_0102, "R8 flag readback", cData, 32'h0201_0102);
    access(1'b1, 12'h400, 32'hFFFF_FFFF, 1'b0);
    chk(cRsp == 2'd0, "R8 hart flag write completes ok", 32'(cRsp), 0);
    access(1'b0, 12'h400, 0, 1'b0);
    chk(cData == 32'h0201_0102, "R8 hart flag write dropped", cData, 32'h0201_0102);
  endtask

  task automatic testRam();
    access(1'b1, 12'h300, 32'hDEAD_0300, 1'b0);
    access(1'b1, 12'h3FC, 32'hBEEF_03FC, 1'b1);
    access(1'b0, 12'h300, 0, 1'b1);
    chk(cData == 32'hDEAD_0300 && cRsp == 2'd0, "R9 jump slot readback", cData, 32'hDEAD_0300);
    access(1'b0, 12'h3FC, 0, 1'b0);
    chk(cData == 32'hBEEF_03FC, "R9 last RAM word readback", cData, 32'hBEEF_03FC);
  endtask

  task automatic testRom();
    access(1'b0, 12'h804, 0, 1'b0);
    chk(cData == 32'hC0DE_0001 && cRsp == 2'd0, "R10 rom read word 1", cData, 32'hC0DE_0001);
    access(1'b0, 12'hFFC, 0, 1'b0);
    chk(cData == 32'hC0DE_01FF, "R10 rom read last word", cData, 32'hC0DE_01FF);
    access(1'b1, 12'h800, 32'd1, 1'b1);
    chk(cRsp == 2'd1, "R10 rom write error", 32'(cRsp), 1);
  endtask

  task automatic testAlert();
    access(1'b1, 12'h000, 32'd1, 1'b0);
    chk(alertFatal == 1'b1, "R11 alert set", 32'(alertFatal), 1);
    access(1'b0, 12'h000, 0, 1'b0);
    chk(cData == 0 && alertFatal == 1'b1, "R11 alert read zero and held", cData, 0);
    access(1'b1, 12'h000, 32'd2, 1'b0);
    chk(alertFatal == 1'b0, "R11 alert cleared by bit0 low", 32'(alertFatal), 0);
  endtask

  task automatic testDecode();
    access(1'b0, 12'h200, 0, 1'b0);
    chk(cRsp == 2'd2, "R12 gap decode error", 32'(cRsp), 2);
    access(1'b1, 12'h404, 32'd3, 1'b1);
    chk(cRsp == 2'd2, "R12 flag beyond hart count", 32'(cRsp), 2);
    @(negedge clk);
    chk(busRspVld == 1'b0, "R13 no response without request", 32'(busRspVld), 0);
  endtask

  task automatic testResetAgain();
    access(1'b1, 12'h000, 32'd1, 1'b0);
    access(1'b1, 12'h100, 32'd3, 1'b0);
    doReset();
    chk(idleMap == 4'd0 && alertFatal == 1'b0, "R1 idle and alert cleared", 32'({idleMap, alertFatal}), 0);
    access(1'b0, 12'h300, 0, 1'b0);
    chk(cData == 0, "R1 RAM cleared by reset", cData, 0);
    access(1'b0, 12'h400, 0, 1'b0);
    chk(cData == 0, "R1 flags cleared by reset", cData, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHalt();
    testGoing();
    testResume();
    testException();
    testActRead();
    testFlags();
    testRam();
    testRom();
    testAlert();
    testDecode();
    testResetAgain();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule